// File: doc/BRIEF.md
# Reader Exchange Sequencer

This block is the control state machine for one contactless reader exchange. On a start command it walks the transmit side through its phases: start-of-frame, payload bytes, an optional CRC phase and end-of-frame. It then turns the link around through two single-cycle intermediate states and a programmable guard wait. Only after that does it arm the receiver, which waits for a signal, receives the reply and returns to idle when the reply ends.

Each phase drives one enable for the coding stage that does the actual work. The sequencer does no bit coding, CRC arithmetic or analog handling itself. It also reports its position as a fixed 3-bit code that software can read from a status register. Both turnaround states share one code. An abort command returns the machine to idle from any state.

Top module: `rfx_frame_seq`

## Requirements
- R1: After reset the state code is 000 and sof_en_o, data_en_o, crc_en_o, eof_en_o and rx_en_o are all low.
- R2: In idle (code 000), start_i with tx_avail_i high moves the machine to the start-of-frame phase in the next cycle: code 001 with sof_en_o high. start_i with tx_avail_i low, or start_i in any state other than idle, has no effect.
- R3: In the start-of-frame phase, a bit_tick_i pulse moves the machine to the data phase: code 010 with data_en_o high. The data phase holds until data_end_i.
- R4: data_end_i in the data phase moves the machine to the CRC phase (code 010, crc_en_o high) when crc_on_i is high, or straight to end-of-frame (code 011, eof_en_o high) when crc_on_i is low. data_end_i in the CRC phase moves it to end-of-frame.
- R5: A bit_tick_i pulse in end-of-frame starts the turnaround. The turnaround is two states that each last exactly one cycle, both report code 100, and both keep all enables low.
- R6: The prepare-receive state (code 101, enables low) holds until rx_wait_i bit_tick_i pulses have been counted. rx_wait_i is sampled in the second turnaround cycle. The state leaves in the cycle after the last tick. A value of 0 gives exactly one cycle in the state.
- R7: The awaiting-receive state (code 110) keeps rx_en_o high and moves to receiving (code 111, rx_en_o high) on rx_detect_i.
- R8: rx_end_i in the receiving state returns the machine to idle (code 000) in the next cycle.
- R9: abort_i returns the machine to idle in the next cycle from every state, and it takes priority over every other input.
- R10: At most one of sof_en_o, data_en_o, crc_en_o and eof_en_o is high at a time. rx_en_o is high exactly in codes 110 and 111 and is never high together with a transmit enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-exchange command strobe |
| abort_i | input | 1 | Abort command, forces idle |
| tx_avail_i | input | 1 | Transmit data is present |
| crc_on_i | input | 1 | Append the CRC phase after the data |
| data_end_i | input | 1 | End of the data or CRC phase |
| bit_tick_i | input | 1 | Bit-clock tick strobe |
| rx_wait_i | input | WAIT_W | Guard wait length in bit ticks |
| rx_detect_i | input | 1 | Receive signal detected |
| rx_end_i | input | 1 | Received frame has ended |
| sof_en_o | output | 1 | Start-of-frame stage enable |
| data_en_o | output | 1 | Data stage enable |
| crc_en_o | output | 1 | CRC stage enable |
| eof_en_o | output | 1 | End-of-frame stage enable |
| rx_en_o | output | 1 | Receiver enable |
| state_code_o | output | 3 | Readable state code |

## Verification
The assertions assume that each strobe input (start, abort, tick, end-of-data, detect, end-of-receive) is a single-cycle pulse. They also assume that rx_wait_i holds steady through the turnaround, since the guard counter samples it only in the second turnaround cycle. The stimulus drives each strobe for exactly one cycle after a clock edge and changes the wait value only while the machine is idle. The sweeps cover every guard value of interest with ticks on every cycle and with ticks spread out, and every abort point.

// File: rtl/rfx_seq_pkg.sv
package rfx_seq_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_TX_SOF  = 4'd1,
    ST_TX_DATA = 4'd2,
    ST_TX_CRC  = 4'd3,
    ST_TX_EOF  = 4'd4,
    ST_TURN_A  = 4'd5,
    ST_TURN_B  = 4'd6,
    ST_RX_PREP = 4'd7,
    ST_RX_WAIT = 4'd8,
    ST_RX_RUN  = 4'd9
  } seq_state_e;

  typedef struct packed {
    logic sof;
    logic data;
    logic crc;
    logic eof;
    logic rx;
  } phase_en_t;

  // Software-visible code; both turnaround states share one value.
  function automatic logic [CODE_W-1:0] state_code(seq_state_e s);
    logic [CODE_W-1:0] c;
    case (s)
      ST_IDLE:    c = 3'b000;
      ST_TX_SOF:  c = 3'b001;
      ST_TX_DATA: c = 3'b010;
      ST_TX_CRC:  c = 3'b010;
      ST_TX_EOF:  c = 3'b011;
      ST_TURN_A:  c = 3'b100;
      ST_TURN_B:  c = 3'b100;
      ST_RX_PREP: c = 3'b101;
      ST_RX_WAIT: c = 3'b110;
      ST_RX_RUN:  c = 3'b111;
      default:    c = 3'b000;
    endcase
    return c;
  endfunction

  function automatic phase_en_t phase_of(seq_state_e s);
    phase_en_t p;
    p      = '0;
    p.sof  = (s == ST_TX_SOF);
    p.data = (s == ST_TX_DATA);
    p.crc  = (s == ST_TX_CRC);
    p.eof  = (s == ST_TX_EOF);
    p.rx   = (s == ST_RX_WAIT) || (s == ST_RX_RUN);
    return p;
  endfunction

endpackage

// File: rtl/rfx_guard_timer.sv
module rfx_guard_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              run_i,
  input  logic              tick_i,
  output logic              expired_o
);

  logic [WAIT_W-1:0] cnt_q;
  logic              step;

  assign step      = run_i && tick_i && (cnt_q != '0);
  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6: the wait value is captured on load
  a_r6_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));

  // R6: without load the count never rises
  a_r6_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> cnt_q <= $past(cnt_q));

  // R6: without a tick the count holds
  a_r6_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rfx_seq_fsm.sv
module rfx_seq_fsm
  import rfx_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       tx_avail_i,
  input  logic       crc_on_i,
  input  logic       data_end_i,
  input  logic       bit_tick_i,
  input  logic       rx_detect_i,
  input  logic       rx_end_i,
  input  logic       guard_zero_i,
  output seq_state_e state_o,
  output logic       ev_launch_o,
  output logic       ev_guard_load_o,
  output logic       ev_guard_run_o
);

  seq_state_e state_q, state_d;

  assign state_o         = state_q;
  assign ev_launch_o     = (state_q == ST_IDLE) && start_i && tx_avail_i && !abort_i;
  assign ev_guard_load_o = (state_q == ST_TURN_B);
  assign ev_guard_run_o  = (state_q == ST_RX_PREP);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start_i && tx_avail_i) state_d = ST_TX_SOF;
      ST_TX_SOF:  if (bit_tick_i) state_d = ST_TX_DATA;
      ST_TX_DATA: if (data_end_i) state_d = crc_on_i ? ST_TX_CRC : ST_TX_EOF;
      ST_TX_CRC:  if (data_end_i) state_d = ST_TX_EOF;
      ST_TX_EOF:  if (bit_tick_i) state_d = ST_TURN_A;
      ST_TURN_A:  state_d = ST_TURN_B;
      ST_TURN_B:  state_d = ST_RX_PREP;
      ST_RX_PREP: if (guard_zero_i) state_d = ST_RX_WAIT;
      ST_RX_WAIT: if (rx_detect_i) state_d = ST_RX_RUN;
      ST_RX_RUN:  if (rx_end_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    if (abort_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> state_q == ST_IDLE);

  a_r2_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_launch_o |=> state_q == ST_TX_SOF);

  a_r5_turn_a_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN_A && !abort_i) |=> state_q == ST_TURN_B);

  a_r5_turn_b_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN_B && !abort_i) |=> state_q == ST_RX_PREP);

  a_r6_prep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_guard_run_o && !guard_zero_i && !abort_i) |=> state_q == ST_RX_PREP);

  a_r7_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX_WAIT && rx_detect_i && !abort_i) |=> state_q == ST_RX_RUN);

  a_r8_rx_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX_RUN && rx_end_i) |=> state_q == ST_IDLE);

endmodule

// File: rtl/rfx_phase_decode.sv
module rfx_phase_decode
  import rfx_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_i,
  output phase_en_t         en_o,
  output logic [CODE_W-1:0] code_o
);

  assign en_o   = phase_of(state_i);
  assign code_o = state_code(state_i);

  a_r10_one_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({en_o.sof, en_o.data, en_o.crc, en_o.eof}));

  a_r10_rx_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o.rx |-> !(en_o.sof || en_o.data || en_o.crc || en_o.eof));

  a_r10_rx_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o.rx == (code_o[2:1] == 2'b11));

  a_r5_turn_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == 3'b100) |-> (en_o == '0));

endmodule

// File: rtl/rfx_frame_seq.sv
module rfx_frame_seq #(
  parameter int WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              tx_avail_i,
  input  logic              crc_on_i,
  input  logic              data_end_i,
  input  logic              bit_tick_i,
  input  logic [WAIT_W-1:0] rx_wait_i,
  input  logic              rx_detect_i,
  input  logic              rx_end_i,
  output logic              sof_en_o,
  output logic              data_en_o,
  output logic              crc_en_o,
  output logic              eof_en_o,
  output logic              rx_en_o,
  output logic [2:0]        state_code_o
);
  import rfx_seq_pkg::*;

  seq_state_e state;
  phase_en_t  en;
  logic       ev_launch, ev_guard_load, ev_guard_run, guard_zero;

  rfx_seq_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .abort_i        (abort_i),
    .tx_avail_i     (tx_avail_i),
    .crc_on_i       (crc_on_i),
    .data_end_i     (data_end_i),
    .bit_tick_i     (bit_tick_i),
    .rx_detect_i    (rx_detect_i),
    .rx_end_i       (rx_end_i),
    .guard_zero_i   (guard_zero),
    .state_o        (state),
    .ev_launch_o    (ev_launch),
    .ev_guard_load_o(ev_guard_load),
    .ev_guard_run_o (ev_guard_run)
  );

  rfx_guard_timer #(.WAIT_W(WAIT_W)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ev_guard_load),
    .load_val_i(rx_wait_i),
    .run_i     (ev_guard_run),
    .tick_i    (bit_tick_i),
    .expired_o (guard_zero)
  );

  rfx_phase_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(state),
    .en_o   (en),
    .code_o (state_code_o)
  );

  assign sof_en_o  = en.sof;
  assign data_en_o = en.data;
  assign crc_en_o  = en.crc;
  assign eof_en_o  = en.eof;
  assign rx_en_o   = en.rx;

  a_r2_launch_sof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_launch |=> (sof_en_o && state_code_o == 3'b001));

  a_r9_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_code_o == 3'b000 && !rx_en_o && !sof_en_o));

endmodule

// File: tb/rfx_frame_seq_tb_top.sv
`timescale 1ns/1ps
module rfx_frame_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 0, abort_c = 0, tx_avail = 0, crc_on = 0;
  logic       data_end = 0, tick = 0, rx_det = 0, rx_end = 0;
  logic [7:0] rx_wait = 8'd0;
  logic       sof_en, data_en, crc_en, eof_en, rx_en;
  logic [2:0] code;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  rfx_frame_seq #(.WAIT_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort_c),
    .tx_avail_i(tx_avail), .crc_on_i(crc_on), .data_end_i(data_end),
    .bit_tick_i(tick), .rx_wait_i(rx_wait), .rx_detect_i(rx_det),
    .rx_end_i(rx_end), .sof_en_o(sof_en), .data_en_o(data_en),
    .crc_en_o(crc_en), .eof_en_o(eof_en), .rx_en_o(rx_en),
    .state_code_o(code)
  );

  // Expected enable patterns {sof,data,crc,eof,rx}
  localparam logic [4:0] E_NONE = 5'b00000, E_SOF = 5'b10000, E_DATA = 5'b01000,
                         E_CRC = 5'b00100, E_EOF = 5'b00010, E_RX = 5'b00001;

  task automatic chk(input string req, input logic [2:0] exp_code, input logic [4:0] exp_en);
    logic [4:0] act;
    act = {sof_en, data_en, crc_en, eof_en, rx_en};
    n_chk++;
    if (code !== exp_code || act !== exp_en) begin
      n_fail++;
      $display("FAIL %s: code=%b en=%b expected code=%b en=%b", req, code, act, exp_code, exp_en);
    end
  endtask

  // One clock: strobes set before the call last exactly this cycle.
  task automatic cyc();
    @(posedge clk);
    #1;
    start = 0; abort_c = 0; data_end = 0; tick = 0; rx_det = 0; rx_end = 0;
    @(negedge clk);
  endtask

  task automatic exchange(input bit crc, input int wait_n, input int gap);
    crc_on = crc; rx_wait = 8'(wait_n); tx_avail = 1;
    chk("R1 idle", 3'b000, E_NONE);
    start = 1; cyc(); chk("R2 sof", 3'b001, E_SOF);
    cyc(); chk("R3 sof holds", 3'b001, E_SOF);
    tick = 1; cyc(); chk("R3 data", 3'b010, E_DATA);
    cyc(); chk("R3 data holds", 3'b010, E_DATA);
    data_end = 1; cyc();
    if (crc) begin
      chk("R4 crc phase", 3'b010, E_CRC);
      data_end = 1; cyc();
    end
    chk("R4 eof", 3'b011, E_EOF);
    tick = 1; cyc(); chk("R5 turn a", 3'b100, E_NONE);
    cyc(); chk("R5 turn b", 3'b100, E_NONE);
    cyc();
    for (int k = 0; k < wait_n; k++) begin
      chk("R6 prep", 3'b101, E_NONE);
      for (int g = 0; g < gap; g++) begin cyc(); chk("R6 prep gap", 3'b101, E_NONE); end
      tick = 1; cyc();
    end
    chk("R6 prep last", 3'b101, E_NONE);
    cyc(); chk("R7 await", 3'b110, E_RX);
    start = 1; cyc(); chk("R2 start ignored busy", 3'b110, E_RX);
    rx_det = 1; cyc(); chk("R7 receiving", 3'b111, E_RX);
    cyc(); chk("R7 receiving holds", 3'b111, E_RX);
    rx_end = 1; cyc(); chk("R8 back idle", 3'b000, E_NONE);
  endtask

  task automatic goto_state(input int target);
    crc_on = 1; rx_wait = 8'd3; tx_avail = 1;
    for (int s = 1; s <= target; s++) begin
      case (s)
        1: begin start = 1; cyc(); end
        2: begin tick = 1; cyc(); end
        3: begin data_end = 1; cyc(); end
        4: begin data_end = 1; cyc(); end
        5: begin tick = 1; cyc(); end
        6: cyc();
        7: cyc();
        8: begin
             for (int t = 0; t < 3; t++) begin tick = 1; cyc(); end
             cyc();
           end
        default: begin rx_det = 1; cyc(); end
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 3'b000, E_NONE);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 3'b000, E_NONE);

    tx_avail = 0; start = 1; cyc(); chk("R2 no data ignored", 3'b000, E_NONE);

    foreach (int_arr_dummy[i]) ;
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 6; w++)
        for (int g = 0; g < 3; g += 2) begin
          int wv;
          case (w) 0: wv = 0; 1: wv = 1; 2: wv = 2; 3: wv = 3; 4: wv = 7; default: wv = 255; endcase
          exchange(c[0], wv, g);
        end

    // R9: abort from every state, even with competing strobes
    for (int st = 0; st <= 9; st++) begin
      goto_state(st);
      abort_c = 1; start = 1; tick = 1; data_end = 1; rx_det = 1; cyc();
      chk("R9 abort to idle", 3'b000, E_NONE);
      cyc(); chk("R9 stays idle", 3'b000, E_NONE);
    end

    // R9: abort during the guard wait, then a fresh exchange runs normally
    goto_state(7);
    chk("R6 prep before abort", 3'b101, E_NONE);
    abort_c = 1; cyc(); chk("R9 abort prep", 3'b000, E_NONE);
    exchange(1'b0, 4, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int int_arr_dummy[1];

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule